// File: doc/BRIEF.md
# Dual-Clock FIFO with Selectable Fall-Through Output

This block is an 18-bit first-in first-out buffer with an independent write clock and read clock. A mode input is captured while reset is held. The mode then selects one of two read behaviours until the next reset.

In standard mode, a word leaves the buffer only on an explicit read. The word appears on the data output after the read-clock edge that performs the read. The write side reports an active-low "full" status and the read side an active-low "empty" status.

In fall-through mode, an output register always holds the oldest word whenever one exists. The read side shows an active-low "output ready" status, and a read acknowledges the word already on view. The output register is extra storage, so the buffer holds one word more than the memory depth. The write side shows an "input ready" status that goes high when no room is left.

The data output is gated by an active-low output enable. The gating is represented as a drive indication rather than a real tristate.

Top module: `dual_mode_fifo`

## Requirements
- R1: In standard mode, after reset `wrFlag` is 1 (not full) and `rdFlag` is 0 (empty).
- R2: In standard mode with no reads since reset, `wrFlag` is still 1 after DEPTH-1 accepted writes and is 0 (full) at the first sample after the DEPTH-th write edge.
- R3: While the write-side flag reports no room (`wrFlag`=0 in standard mode, `wrFlag`=1 in fall-through mode), a write strobe (`wrEnN`=0) stores nothing. This shows as the drained word count not growing.
- R4: In standard mode, while `rdFlag` is 0, a read strobe (`rdEnN`=0) leaves `rdData` and `rdFlag` unchanged.
- R5: When `outEnN` is 1, `rdDrive` is 0 and `rdData` is all zeros. When `outEnN` is 0, `rdDrive` is 1 and `rdData` shows the output register.
- R6: In fall-through mode, after reset `wrFlag` is 0 (input ready) and `rdFlag` is 1 (no word on view).
- R7: In fall-through mode, `rdFlag` falls to 0 in the same read cycle that the first word written into the empty buffer appears on `rdData`.
- R8: In fall-through mode with no reads, `wrFlag` stays 0 after DEPTH accepted writes once the pointers settle. It goes to 1 right after write DEPTH+1.
- R9: In fall-through mode, `rdFlag` returns to 1 only after a read strobe. After the last word is read, `rdData` keeps that word, and further read strobes change neither `rdData` nor `rdFlag`.
- R10: The mode is taken from `modeFwft` only while `rstN` is 0. Changing `modeFwft` afterwards has no effect on flag behaviour.
- R11: Words leave in the order they were accepted, with intact values, under interleaved writes and reads on the two unrelated clocks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wrClk | input | 1 | Write clock |
| rdClk | input | 1 | Read clock |
| rstN | input | 1 | Asynchronous active-low reset for both domains |
| modeFwft | input | 1 | 1 selects fall-through mode; sampled only during reset |
| wrEnN | input | 1 | Active-low write strobe |
| wrData | input | 18 | Write data |
| wrFlag | output | 1 | Standard: not-full (low = full). Fall-through: high = no room |
| rdEnN | input | 1 | Active-low read strobe |
| outEnN | input | 1 | Active-low output enable |
| rdData | output | 18 | Read data, zero when not enabled |
| rdDrive | output | 1 | High when the data output is being driven |
| rdFlag | output | 1 | Standard: not-empty (low = empty). Fall-through: low = word valid |

## Verification
The bench attacks the capacity edges of both modes. A design that counts the output register wrongly in fall-through mode reports full one word early or late. A design that does not block writes at full overwrites the oldest word, and the scoreboard then sees a wrong value or an extra word while draining. The bench also strobes reads on an empty buffer and after the last fall-through word. A design that advances anyway would alter the held data or re-raise the valid status. Changing the mode pin mid-run exposes a mode that was not latched at reset.

// File: rtl/fifo_pkg.sv
package fifo_pkg;
  // Strobes handed from control to datapath each cycle of their own clock.
  typedef struct packed {
    logic wrPush;   // write clock domain: store wrData at wrAddr
    logic outLoad;  // read clock domain: load output register from rdAddr
  } fifoStrobes_t;
endpackage

// File: rtl/fifo_gray_sync.sv
module fifo_gray_sync #(
  parameter int WIDTH  = 5,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] dout
);
  logic [WIDTH-1:0] stage [STAGES];

  genvar gi;
  generate
    for (gi = 0; gi < STAGES; gi++) begin : g_stage
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) stage[gi] <= '0;
        else if (gi == 0) stage[gi] <= din;
        else stage[gi] <= stage[(gi == 0) ? 0 : gi-1];
      end
    end
  endgenerate

  assign dout = stage[STAGES-1];
endmodule

// File: rtl/fifo_ctrl.sv
module fifo_ctrl #(
  parameter int ADDR_W      = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic                    wrClk,
  input  logic                    rdClk,
  input  logic                    rstN,
  input  logic                    modeFwft,
  input  logic                    wrEnN,
  input  logic                    rdEnN,
  output logic                    wrFlag,
  output logic                    rdFlag,
  output fifo_pkg::fifoStrobes_t  strobe,
  output logic [ADDR_W-1:0]       wrAddr,
  output logic [ADDR_W-1:0]       rdAddr,
  output logic                    modeRd,
  output logic                    fullInd,
  output logic                    emptyInd
);
  localparam int PTR_W = ADDR_W + 1;

  // ---------------- write clock domain ----------------
  logic             modeWr;
  logic [PTR_W-1:0] wrBin, wrBinNext, wrGray, wrGrayNext;
  logic [PTR_W-1:0] rdGraySync, rdGrayFull;
  logic [PTR_W-1:0] rdGray;
  logic             fullReg, fullNext, wrPush;

  always_ff @(posedge wrClk) begin
    if (!rstN) modeWr <= modeFwft;
  end

  assign wrPush     = !wrEnN && !fullReg;
  assign wrBinNext  = wrBin + PTR_W'(wrPush);
  assign wrGrayNext = (wrBinNext >> 1) ^ wrBinNext;
  assign rdGrayFull = {~rdGraySync[PTR_W-1:PTR_W-2], rdGraySync[PTR_W-3:0]};
  assign fullNext   = (wrGrayNext == rdGrayFull);

  always_ff @(posedge wrClk or negedge rstN) begin
    if (!rstN) begin
      wrBin   <= '0;
      wrGray  <= '0;
      fullReg <= 1'b0;
    end else begin
      wrBin   <= wrBinNext;
      wrGray  <= wrGrayNext;
      fullReg <= fullNext;
    end
  end

  fifo_gray_sync #(.WIDTH(PTR_W), .STAGES(SYNC_STAGES)) u_rdToWr (
    .clk(wrClk), .rstN(rstN), .din(rdGray), .dout(rdGraySync)
  );

  // ---------------- read clock domain ----------------
  logic [PTR_W-1:0] rdBin, rdBinNext, rdGrayNext, wrGraySync;
  logic             emptyReg, emptyNext, rdLoad, outValid;

  always_ff @(posedge rdClk) begin
    if (!rstN) modeRd <= modeFwft;
  end

  always_comb begin
    if (modeRd) rdLoad = !emptyReg && (!outValid || !rdEnN);
    else        rdLoad = !emptyReg && !rdEnN;
  end

  assign rdBinNext  = rdBin + PTR_W'(rdLoad);
  assign rdGrayNext = (rdBinNext >> 1) ^ rdBinNext;
  assign emptyNext  = (rdGrayNext == wrGraySync);

  always_ff @(posedge rdClk or negedge rstN) begin
    if (!rstN) begin
      rdBin    <= '0;
      rdGray   <= '0;
      emptyReg <= 1'b1;
      outValid <= 1'b0;
    end else begin
      rdBin    <= rdBinNext;
      rdGray   <= rdGrayNext;
      emptyReg <= emptyNext;
      if (!modeRd)     outValid <= 1'b0;
      else if (rdLoad) outValid <= 1'b1;
      else if (!rdEnN) outValid <= 1'b0;
    end
  end

  fifo_gray_sync #(.WIDTH(PTR_W), .STAGES(SYNC_STAGES)) u_wrToRd (
    .clk(rdClk), .rstN(rstN), .din(wrGray), .dout(wrGraySync)
  );

  // ---------------- outputs ----------------
  assign wrFlag         = modeWr ? fullReg : !fullReg;
  assign rdFlag         = modeRd ? !outValid : !emptyReg;
  assign strobe.wrPush  = wrPush;
  assign strobe.outLoad = rdLoad;
  assign wrAddr         = wrBin[ADDR_W-1:0];
  assign rdAddr         = rdBin[ADDR_W-1:0];
  assign fullInd        = fullReg;
  assign emptyInd       = emptyReg;
endmodule

// File: rtl/fifo_datapath.sv
module fifo_datapath #(
  parameter int DATA_W = 18,
  parameter int ADDR_W = 4
) (
  input  logic                   wrClk,
  input  logic                   rdClk,
  input  logic                   rstN,
  input  fifo_pkg::fifoStrobes_t strobe,
  input  logic [ADDR_W-1:0]      wrAddr,
  input  logic [ADDR_W-1:0]      rdAddr,
  input  logic [DATA_W-1:0]      wrData,
  input  logic                   outEnN,
  output logic [DATA_W-1:0]      rdData,
  output logic                   rdDrive
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] mem [DEPTH];
  logic [DATA_W-1:0] outReg;

  always_ff @(posedge wrClk) begin
    if (strobe.wrPush) mem[wrAddr] <= wrData;
  end

  always_ff @(posedge rdClk or negedge rstN) begin
    if (!rstN) outReg <= '0;
    else if (strobe.outLoad) outReg <= mem[rdAddr];
  end

  assign rdDrive = !outEnN;
  assign rdData  = outEnN ? '0 : outReg;
endmodule

// File: rtl/dual_mode_fifo.sv
module dual_mode_fifo #(
  parameter int DATA_W      = 18,
  parameter int ADDR_W      = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic              wrClk,
  input  logic              rdClk,
  input  logic              rstN,
  input  logic              modeFwft,
  input  logic              wrEnN,
  input  logic [DATA_W-1:0] wrData,
  output logic              wrFlag,
  input  logic              rdEnN,
  input  logic              outEnN,
  output logic [DATA_W-1:0] rdData,
  output logic              rdDrive,
  output logic              rdFlag
);
  fifo_pkg::fifoStrobes_t strobe;
  logic [ADDR_W-1:0]      wrAddr, rdAddr;
  logic                   modeRd, fullInd, emptyInd;

  fifo_ctrl #(.ADDR_W(ADDR_W), .SYNC_STAGES(SYNC_STAGES)) u_ctrl (
    .wrClk(wrClk), .rdClk(rdClk), .rstN(rstN), .modeFwft(modeFwft),
    .wrEnN(wrEnN), .rdEnN(rdEnN), .wrFlag(wrFlag), .rdFlag(rdFlag),
    .strobe(strobe), .wrAddr(wrAddr), .rdAddr(rdAddr), .modeRd(modeRd),
    .fullInd(fullInd), .emptyInd(emptyInd)
  );

  fifo_datapath #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_data (
    .wrClk(wrClk), .rdClk(rdClk), .rstN(rstN), .strobe(strobe),
    .wrAddr(wrAddr), .rdAddr(rdAddr), .wrData(wrData), .outEnN(outEnN),
    .rdData(rdData), .rdDrive(rdDrive)
  );
endmodule

// File: rtl/fifo_checker.sv
module fifo_checker #(
  parameter int DATA_W = 18
) (
  input logic              wrClk,
  input logic              rdClk,
  input logic              rstN,
  input logic              modeFwft,
  input logic              wrPush,
  input logic              outLoad,
  input logic              fullInd,
  input logic              emptyInd,
  input logic              modeRd,
  input logic              rdEnN,
  input logic              outEnN,
  input logic              rdFlag,
  input logic [DATA_W-1:0] rdData
);
  // Full may only appear after a write was accepted (R2)
  assert_full_after_write_R2: assert property (@(posedge wrClk) disable iff (!rstN)
    $rose(fullInd) |-> $past(wrPush));

  // Empty may only appear after a word left memory (R4)
  assert_empty_after_read_R4: assert property (@(posedge rdClk) disable iff (!rstN)
    $rose(emptyInd) |-> $past(outLoad));

  // Fall-through valid status clears only on a true read (R9)
  assert_or_true_read_R9: assert property (@(posedge rdClk) disable iff (!rstN)
    (modeRd && $rose(rdFlag)) |-> $past(!rdEnN));

  // With nothing valid in fall-through mode, the shown data holds (R9)
  assert_hold_after_last_R9: assert property (@(posedge rdClk) disable iff (!rstN)
    (modeRd && rdFlag && $past(rdFlag) && !outEnN && $past(!outEnN)) |-> $stable(rdData));

  // Latched mode never changes outside reset (R10)
  assert_mode_fixed_R10: assert property (@(posedge rdClk) disable iff (!rstN)
    $stable(modeRd));
endmodule

bind dual_mode_fifo fifo_checker #(.DATA_W(DATA_W)) u_chk (
  .wrClk(wrClk), .rdClk(rdClk), .rstN(rstN), .modeFwft(modeFwft),
  .wrPush(strobe.wrPush), .outLoad(strobe.outLoad), .fullInd(fullInd),
  .emptyInd(emptyInd), .modeRd(modeRd), .rdEnN(rdEnN), .outEnN(outEnN),
  .rdFlag(rdFlag), .rdData(rdData)
);

// File: tb/sim_dual_mode_fifo.sv
module sim_dual_mode_fifo;
  localparam int DATA_W = 18;
  localparam int DEPTH  = 16;

  // wrClk period 20 units stands for 50 MHz; rdClk runs unrelated at 28 units.
  logic wrClk = 1'b0, rdClk = 1'b0;
  always #10 wrClk = ~wrClk;
  always #14 rdClk = ~rdClk;

  logic rstN = 1'b0, modeFwft = 1'b0, wrEnN = 1'b1, rdEnN = 1'b1, outEnN = 1'b0;
  logic [DATA_W-1:0] wrData = '0;
  logic wrFlag, rdFlag, rdDrive;
  logic [DATA_W-1:0] rdData;

  dual_mode_fifo u0 (
    .wrClk(wrClk), .rdClk(rdClk), .rstN(rstN), .modeFwft(modeFwft),
    .wrEnN(wrEnN), .wrData(wrData), .wrFlag(wrFlag), .rdEnN(rdEnN),
    .outEnN(outEnN), .rdData(rdData), .rdDrive(rdDrive), .rdFlag(rdFlag)
  );

  int checks = 0, bad = 0;
  bit benchFwft = 0, finished = 0;
  logic [DATA_W-1:0] expQ[$];

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic doReset(input bit fwft);
    rstN = 1'b0; benchFwft = fwft; modeFwft = fwft;
    wrEnN = 1'b1; rdEnN = 1'b1; outEnN = 1'b0;
    expQ.delete();
    repeat (4) @(posedge wrClk);
    repeat (4) @(posedge rdClk);
    @(negedge wrClk) rstN = 1'b1;
    @(negedge wrClk);
  endtask

  function automatic bit roomNow();
    return benchFwft ? !wrFlag : wrFlag;
  endfunction

  // Driver: strobe one write, record it as expected when room was reported.
  task automatic writeWord(input logic [DATA_W-1:0] d, output bit took);
    @(negedge wrClk);
    took = roomNow();
    if (took) expQ.push_back(d);
    wrData = d; wrEnN = 1'b0;
    @(negedge wrClk) wrEnN = 1'b1;
  endtask

  task automatic settle();
    repeat (12) @(negedge wrClk);
    repeat (6) @(negedge rdClk);
  endtask

  // Monitor side: take one word and compare it with the scoreboard head (R11).
  task automatic readWord(input string tag, output bit got);
    logic [DATA_W-1:0] e;
    got = 0;
    @(negedge rdClk);
    if (!benchFwft) begin
      if (rdFlag) begin
        rdEnN = 1'b0;
        @(negedge rdClk) rdEnN = 1'b1;
        e = (expQ.size() > 0) ? expQ.pop_front() : '1;
        check(rdData == e, tag, rdData, e);
        got = 1;
      end
    end else if (!rdFlag) begin
      e = (expQ.size() > 0) ? expQ.pop_front() : '1;
      check(rdData == e, tag, rdData, e);
      rdEnN = 1'b0;
      @(negedge rdClk) rdEnN = 1'b1;
      got = 1;
    end
  endtask

  task automatic drainAll(input string tag, output int n);
    bit got;
    int idle = 0;
    n = 0;
    while (idle < 20) begin
      readWord(tag, got);
      if (got) begin n++; idle = 0; end
      else idle++;
    end
  endtask

  initial begin
    repeat (150000) @(posedge wrClk);
    if (!finished) begin
      bad++; checks++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("  test done: total=%0d bad=%0d", checks, bad);
      $finish;
    end
  end

  initial begin
    bit took;
    int n;
    logic [DATA_W-1:0] held;

    // ---------------- standard mode ----------------
    doReset(1'b0);
    check(wrFlag == 1'b1, "R1 not-full after reset", wrFlag, 1);
    check(rdFlag == 1'b0, "R1 empty after reset", rdFlag, 0);

    for (int i = 0; i < DEPTH-1; i++) writeWord(18'h10000 + i, took);
    settle();
    check(wrFlag == 1'b1, "R2 not full at DEPTH-1", wrFlag, 1);
    writeWord(18'h1FFFF, took);
    check(wrFlag == 1'b0, "R2 full after DEPTH writes", wrFlag, 0);
    writeWord(18'h3ABCD, took);
    check(took == 1'b0, "R3 room reported while full", took, 0);
    drainAll("R11 standard drain", n);
    check(n == DEPTH, "R3 word count after blocked write", n, DEPTH);

    held = rdData;
    @(negedge rdClk) rdEnN = 1'b0;
    repeat (2) @(negedge rdClk);
    check(rdData == held, "R4 data unchanged by read when empty", rdData, held);
    check(rdFlag == 1'b0, "R4 still empty", rdFlag, 0);
    rdEnN = 1'b1;

    @(negedge rdClk) outEnN = 1'b1;
    #1;
    check(rdDrive == 1'b0, "R5 no drive when disabled", rdDrive, 0);
    check(rdData == '0, "R5 data zero when disabled", rdData, 0);
    outEnN = 1'b0;
    #1;
    check(rdDrive == 1'b1 && rdData == held, "R5 data shown when enabled", rdData, held);

    modeFwft = 1'b1;
    writeWord(18'h05555, took);
    settle();
    check(rdFlag == 1'b1, "R10 standard flag kept after pin change", rdFlag, 1);
    check(wrFlag == 1'b1, "R10 write flag polarity kept", wrFlag, 1);
    drainAll("R10 read after pin change", n);
    check(n == 1, "R10 one word drained", n, 1);
    modeFwft = 1'b0;

    // interleaved stream on both clocks
    fork
      begin
        int sent = 0;
        while (sent < 40) begin
          writeWord(18'h20000 + sent * 37, took);
          if (took) sent++;
        end
      end
      begin
        int rcv = 0;
        bit got;
        while (rcv < 40) begin
          readWord("R11 interleaved order", got);
          if (got) rcv++;
        end
      end
    join
    check(expQ.size() == 0, "R11 all words returned", expQ.size(), 0);

    // ---------------- fall-through mode ----------------
    doReset(1'b1);
    check(wrFlag == 1'b0, "R6 input ready after reset", wrFlag, 0);
    check(rdFlag == 1'b1, "R6 nothing valid after reset", rdFlag, 1);

    writeWord(18'h2A5A5, took);
    begin
      bit seen = 0;
      for (int k = 0; k < 20 && !seen; k++) begin
        @(negedge rdClk);
        if (!rdFlag) begin
          seen = 1;
          check(rdData == 18'h2A5A5, "R7 data valid with flag", rdData, 18'h2A5A5);
        end
      end
      check(seen, "R7 flag fell", seen, 1);
    end
    settle();

    for (int i = 1; i < DEPTH; i++) writeWord(18'h30000 + i, took);
    settle();
    check(wrFlag == 1'b0, "R8 room left after DEPTH writes", wrFlag, 0);
    writeWord(18'h3FFF0, took);
    check(wrFlag == 1'b1, "R8 no room after DEPTH+1 writes", wrFlag, 1);
    writeWord(18'h01234, took);
    check(took == 1'b0, "R3 room reported in fall-through full", took, 0);
    check(rdFlag == 1'b0, "R9 still valid before any read", rdFlag, 0);

    drainAll("R11 fall-through drain", n);
    check(n == DEPTH + 1, "R8 drained DEPTH+1 words", n, DEPTH + 1);
    check(rdFlag == 1'b1, "R9 flag high after last read", rdFlag, 1);
    check(rdData == 18'h3FFF0, "R9 last word held", rdData, 18'h3FFF0);
    @(negedge rdClk) rdEnN = 1'b0;
    repeat (3) @(negedge rdClk);
    check(rdData == 18'h3FFF0, "R9 extra reads keep data", rdData, 18'h3FFF0);
    check(rdFlag == 1'b1, "R9 extra reads keep flag", rdFlag, 1);
    rdEnN = 1'b1;

    finished = 1;
    $display("  test done: total=%0d bad=%0d", checks, bad);
    $finish;
  end
endmodule